// File: doc/BRIEF.md
# Dual-Side Boundary Scan Ring with Signature, Pattern and Count Self-Test

This block is the test logic that sits around the pins of a bidirectional bus transceiver. Each pin has two scan cells, one on the A side and one on the B side. Test data can therefore be captured from, or forced onto, either bus independently. A capture/shift register on each side takes pin snapshots and forms the serial chain. An update register on each side holds the values forced onto the pins while the block is in a driving mode.

An external test-port controller supplies a 3-bit operation code and four phase strobes (capture, shift, run-idle, update). That controller is not part of this block. In the plain sampling operation the transceiver's own data paths reach the pins untouched, and the chain can be captured, shifted and preloaded in the background.

The other operations have the update registers drive the pins. The chain can also turn into a multiple-input signature compressor, the update registers into a pseudo-random pattern source, or the two combine so that signatures are gathered while a binary counter walks an address range. Everything steps on the test clock. Chain activity happens on rising edges. Update-register activity happens on falling edges, so forced pin values never change while the chain is moving.

Top module: `xcvr_bscan_ring`

## Requirements
- R1: A synchronous active-high reset clears every capture/shift cell (on a rising edge) and every update cell (on a falling edge), so tdo reads 0 and driven pins read 0.
- R2: Operation code 0 and codes 5 to 7 are non-driving: a_pin_out follows core_b2a, b_pin_out follows core_a2b and test_mode is 0. Codes 1 (external test), 2 (signature), 3 (pattern) and 4 (signature plus count) set test_mode to 1. In those codes, a_pin_out shows the A update cells and b_pin_out shows the B update cells.
- R3: A rising edge with st_capture loads a_pin_in into the A capture cells and b_pin_in into the B capture cells, whatever the operation code.
- R4: The serial chain runs from tdi into B cell W-1, down through B cell 0 into A cell W-1, and down to A cell 0, which is tdo. A rising edge with st_shift (and no st_capture) moves every cell one place toward tdo. A 2W-bit vector shifted in least significant bit first therefore leaves A cells = bits W-1..0 and B cells = bits 2W-1..W.
- R5: A falling edge with st_update copies the capture cells of each side into that side's update cells. Driven pins change only on such an edge, or on a self-test step.
- R6: In a non-driving operation, capture, shift and update activity leaves the pin outputs equal to the core paths. The preloaded update cells appear on the pins once a driving code is selected.
- R7: In codes 2 and 4, a rising edge with st_idle replaces each side's cells s with {s[W-2:0], s[W-1]^s[TAP-1]} XOR that side's pin input (W=18, TAP=11 by default, the polynomial x^18+x^11+1).
- R8: In code 3, a falling edge with st_idle (and no st_update) steps each update register to {s[W-2:0], s[W-1]^s[TAP-1]}. A register that is all zeros is loaded with the reseed value instead (default 1), so the output is never all zeros after a step.
- R9: In code 4, a falling edge with st_idle (and no st_update) adds 1 to each update register modulo 2^W, so the all-ones value wraps to zero.
- R10: On a rising edge, st_capture takes priority over st_shift, and st_shift over a signature step. On a rising edge with none of them active (including st_idle in codes 0, 1, 3 and 5 to 7), the chain holds its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; chain on rising edge, update cells on falling edge |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Decoded operation code (0 sample/preload, 1 external test, 2 signature, 3 pattern, 4 signature plus count) |
| st_capture | input | 1 | Capture-phase strobe |
| st_shift | input | 1 | Shift-phase strobe |
| st_idle | input | 1 | Run-idle strobe, steps the self-test modes |
| st_update | input | 1 | Update-phase strobe |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out (A cell 0) |
| a_pin_in | input | PIN_W | Values seen at the A-bus pins |
| b_pin_in | input | PIN_W | Values seen at the B-bus pins |
| core_b2a | input | PIN_W | Transceiver's normal data toward the A bus |
| core_a2b | input | PIN_W | Transceiver's normal data toward the B bus |
| a_pin_out | output | PIN_W | Data driven onto the A bus |
| b_pin_out | output | PIN_W | Data driven onto the B bus |
| test_mode | output | 1 | High when the update cells own the pins |

## Verification
The checker assumes the strobes come from a well-formed test-port controller. Strobes change only between edges, at most one of shift, run-idle and update is high at a time, the operation code is steady across the falling and rising edges of a step, and reset is held across at least one falling edge. The stimulus sets code and strobes a millisecond-free nanosecond after each rising edge and holds them for one full period. It raises a single strobe at a time, except for one deliberate capture-with-shift cycle, which the shift property leaves out by its antecedent.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    localparam int DEF_PIN_W = 18;
    localparam int DEF_FB_TAP = 11;

    typedef enum logic [2:0] {
        OP_SAMPLE  = 3'd0,
        OP_EXTEST  = 3'd1,
        OP_SIGN    = 3'd2,
        OP_PATGEN  = 3'd3,
        OP_SIGNCNT = 3'd4
    } scan_op_e;

    typedef struct packed {
        logic drive_pins;
        logic sig_on;
        logic gen_on;
        logic cnt_on;
    } scan_mode_t;

    function automatic scan_mode_t decode_op(input logic [2:0] code);
        scan_mode_t m;
        m = '0;
        case (code)
            OP_EXTEST:  m.drive_pins = 1'b1;
            OP_SIGN:    begin m.drive_pins = 1'b1; m.sig_on = 1'b1; end
            OP_PATGEN:  begin m.drive_pins = 1'b1; m.gen_on = 1'b1; end
            OP_SIGNCNT: begin m.drive_pins = 1'b1; m.sig_on = 1'b1; m.cnt_on = 1'b1; end
            default:    m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/bscan_lfsr_next.sv
module bscan_lfsr_next #(
    parameter int W   = 18,
    parameter int TAP = 11
) (
    input  logic [W-1:0] state,
    input  logic [W-1:0] inject,
    output logic [W-1:0] nxt
);
    logic fb;

    always_comb begin
        fb  = state[W-1] ^ state[TAP-1];
        nxt = {state[W-2:0], fb} ^ inject;
    end
endmodule

// File: rtl/bscan_cap_side.sv
module bscan_cap_side #(
    parameter int W   = 18,
    parameter int TAP = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         do_cap,
    input  logic         do_shift,
    input  logic         do_sig,
    input  logic [W-1:0] pin_in,
    input  logic         ser_in,
    output logic [W-1:0] cells,
    output logic         ser_out
);
    logic [W-1:0] sig_nxt;

    bscan_lfsr_next #(.W(W), .TAP(TAP)) u_sig (
        .state  (cells),
        .inject (pin_in),
        .nxt    (sig_nxt)
    );

    // capture wins over shift, shift over a signature step
    always_ff @(posedge clk) begin
        if (rst)
            cells <= '0;
        else if (do_cap)
            cells <= pin_in;
        else if (do_shift)
            cells <= {ser_in, cells[W-1:1]};
        else if (do_sig)
            cells <= sig_nxt;
    end

    assign ser_out = cells[0];
endmodule

// File: rtl/bscan_upd_side.sv
module bscan_upd_side #(
    parameter int           W    = 18,
    parameter int           TAP  = 11,
    parameter logic [W-1:0] SEED = W'(1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         do_load,
    input  logic         do_gen,
    input  logic         do_cnt,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cells
);
    logic [W-1:0] gen_nxt;
    logic         all_zero;

    bscan_lfsr_next #(.W(W), .TAP(TAP)) u_gen (
        .state  (cells),
        .inject ('0),
        .nxt    (gen_nxt)
    );

    assign all_zero = (cells == '0);

    // falling edge: forced values move only while the chain is still
    always_ff @(negedge clk) begin
        if (rst)
            cells <= '0;
        else if (do_load)
            cells <= load_val;
        else if (do_gen)
            cells <= all_zero ? SEED : gen_nxt;
        else if (do_cnt)
            cells <= cells + W'(1);
    end
endmodule

// File: rtl/xcvr_bscan_ring.sv
module xcvr_bscan_ring
    import bscan_pkg::*;
#(
    parameter int                PIN_W  = DEF_PIN_W,
    parameter int                FB_TAP = DEF_FB_TAP,
    parameter logic [PIN_W-1:0]  RESEED = PIN_W'(1)
) (
    input  logic             tck,
    input  logic             rst,
    input  logic [2:0]       op,
    input  logic             st_capture,
    input  logic             st_shift,
    input  logic             st_idle,
    input  logic             st_update,
    input  logic             tdi,
    output logic             tdo,
    input  logic [PIN_W-1:0] a_pin_in,
    input  logic [PIN_W-1:0] b_pin_in,
    input  logic [PIN_W-1:0] core_b2a,
    input  logic [PIN_W-1:0] core_a2b,
    output logic [PIN_W-1:0] a_pin_out,
    output logic [PIN_W-1:0] b_pin_out,
    output logic             test_mode
);
    localparam int SIDES = 2;
    localparam int SIDE_A = 0;
    localparam int SIDE_B = 1;

    scan_mode_t       mode;
    logic [PIN_W-1:0] side_pin [SIDES];
    logic [PIN_W-1:0] cap_q    [SIDES];
    logic [PIN_W-1:0] upd_q    [SIDES];
    logic [SIDES:0]   ser_link;

    assign mode = decode_op(op);

    assign side_pin[SIDE_A] = a_pin_in;
    assign side_pin[SIDE_B] = b_pin_in;
    assign ser_link[SIDES]  = tdi;

    for (genvar gs = 0; gs < SIDES; gs++) begin : g_side
        bscan_cap_side #(.W(PIN_W), .TAP(FB_TAP)) u_cap (
            .clk      (tck),
            .rst      (rst),
            .do_cap   (st_capture),
            .do_shift (st_shift),
            .do_sig   (mode.sig_on & st_idle),
            .pin_in   (side_pin[gs]),
            .ser_in   (ser_link[gs+1]),
            .cells    (cap_q[gs]),
            .ser_out  (ser_link[gs])
        );

        bscan_upd_side #(.W(PIN_W), .TAP(FB_TAP), .SEED(RESEED)) u_upd (
            .clk      (tck),
            .rst      (rst),
            .do_load  (st_update),
            .do_gen   (mode.gen_on & st_idle),
            .do_cnt   (mode.cnt_on & st_idle),
            .load_val (cap_q[gs]),
            .cells    (upd_q[gs])
        );
    end

    assign tdo       = ser_link[0];
    assign test_mode = mode.drive_pins;

    always_comb begin
        if (mode.drive_pins) begin
            a_pin_out = upd_q[SIDE_A];
            b_pin_out = upd_q[SIDE_B];
        end else begin
            a_pin_out = core_b2a;
            b_pin_out = core_a2b;
        end
    end
endmodule

// File: rtl/xcvr_bscan_ring_chk.sv
module xcvr_bscan_ring_chk
    import bscan_pkg::*;
#(
    parameter int PIN_W = 18
) (
    input logic               tck,
    input logic               rst,
    input logic [2:0]         op,
    input logic               st_capture,
    input logic               st_shift,
    input logic               st_idle,
    input logic               st_update,
    input logic               tdi,
    input logic               tdo,
    input logic [PIN_W-1:0]   a_pin_in,
    input logic [2*PIN_W-1:0] chain,
    input logic [PIN_W-1:0]   upd_a,
    input logic [PIN_W-1:0]   upd_b
);
    logic sig_op;
    logic gen_op;
    logic cnt_op;

    assign sig_op = (op == OP_SIGN) || (op == OP_SIGNCNT);
    assign gen_op = (op == OP_PATGEN);
    assign cnt_op = (op == OP_SIGNCNT);

    // R3: a captured A pin 0 is the next bit seen on tdo
    a_r3_capture_to_tdo: assert property (@(posedge tck) disable iff (rst)
        st_capture |=> tdo == $past(a_pin_in[0]));

    // R4: one shift moves the whole chain one cell toward tdo
    a_r4_shift_step: assert property (@(posedge tck) disable iff (rst)
        (st_shift && !st_capture) |=> chain == {$past(tdi), $past(chain[2*PIN_W-1:1])});

    // R10: no chain activity means no chain change
    a_r10_chain_holds: assert property (@(posedge tck) disable iff (rst)
        (!st_capture && !st_shift && !(st_idle && sig_op)) |=> $stable(chain));

    // R5: forced values move only on update or a self-test step
    a_r5_forced_quiet: assert property (@(negedge tck) disable iff (rst)
        (!st_update && !(st_idle && (gen_op || cnt_op))) |=> ($stable(upd_a) && $stable(upd_b)));

    // R8: a pattern step never leaves an all-zero register
    a_r8_gen_nonzero: assert property (@(negedge tck) disable iff (rst)
        (st_idle && !st_update && gen_op) |=> (upd_a != '0 && upd_b != '0));

    // R9: a count step adds exactly one, wrapping at all ones
    a_r9_count_step: assert property (@(negedge tck) disable iff (rst)
        (st_idle && !st_update && cnt_op) |=> upd_b == PIN_W'($past(upd_b) + PIN_W'(1)));
endmodule

bind xcvr_bscan_ring xcvr_bscan_ring_chk #(.PIN_W(PIN_W)) u_chk (
    .tck        (tck),
    .rst        (rst),
    .op         (op),
    .st_capture (st_capture),
    .st_shift   (st_shift),
    .st_idle    (st_idle),
    .st_update  (st_update),
    .tdi        (tdi),
    .tdo        (tdo),
    .a_pin_in   (a_pin_in),
    .chain      ({cap_q[1], cap_q[0]}),
    .upd_a      (upd_q[0]),
    .upd_b      (upd_q[1])
);

// File: tb/xcvr_bscan_ring_bench.sv
module xcvr_bscan_ring_bench;
    localparam int W   = 18;
    localparam int TAP = 11;
    localparam int CW  = 2 * W;

    logic         tck = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   op = 3'd0;
    logic         st_capture = 1'b0;
    logic         st_shift = 1'b0;
    logic         st_idle = 1'b0;
    logic         st_update = 1'b0;
    logic         tdi = 1'b0;
    logic         tdo;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] core_ba = '0;
    logic [W-1:0] core_ab = '0;
    logic [W-1:0] a_out;
    logic [W-1:0] b_out;
    logic         tmode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 tck = ~tck;

    xcvr_bscan_ring u_xcvr_bscan_ring (
        .tck        (tck),
        .rst        (rst),
        .op         (op),
        .st_capture (st_capture),
        .st_shift   (st_shift),
        .st_idle    (st_idle),
        .st_update  (st_update),
        .tdi        (tdi),
        .tdo        (tdo),
        .a_pin_in   (a_in),
        .b_pin_in   (b_in),
        .core_b2a   (core_ba),
        .core_a2b   (core_ab),
        .a_pin_out  (a_out),
        .b_pin_out  (b_out),
        .test_mode  (tmode)
    );

    task automatic cycle();
        @(posedge tck);
        #1;
    endtask

    task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] lstep(input logic [W-1:0] s, input logic [W-1:0] d);
        return {s[W-2:0], s[W-1] ^ s[TAP-1]} ^ d;
    endfunction

    task automatic shift_chain(input logic [CW-1:0] vin, output logic [CW-1:0] vout);
        logic [CW-1:0] got;
        got = '0;
        for (int i = 0; i < CW; i++) begin
            tdi = vin[i];
            got[i] = tdo;
            st_shift = 1'b1;
            cycle();
        end
        st_shift = 1'b0;
        tdi = 1'b0;
        vout = got;
    endtask

    task automatic pulse_capture();
        st_capture = 1'b1;
        cycle();
        st_capture = 1'b0;
    endtask

    task automatic pulse_update();
        st_update = 1'b1;
        cycle();
        st_update = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge tck);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] vin;
        logic [CW-1:0] got;
        logic [W-1:0]  ma, mb, ca, cb;

        repeat (3) cycle();
        rst = 1'b0;

        // R1: reset state seen through a driving code
        op = 3'd1;
        cycle();
        check("R1 a_pin_out after reset", a_out, '0);
        check("R1 b_pin_out after reset", b_out, '0);
        check("R1 tdo after reset", tdo, 1'b0);
        check("R2 test_mode code 1", tmode, 1'b1);

        // R2/R6: non-driving code, background preload
        op = 3'd0;
        core_ab = W'($urandom);
        core_ba = W'($urandom);
        cycle();
        check("R2 b_pin_out follows core", b_out, core_ab);
        check("R2 test_mode code 0", tmode, 1'b0);
        vin = {W'($urandom), W'($urandom)};
        pulse_capture();
        shift_chain(vin, got);
        pulse_update();
        check("R6 a_pin_out untouched by update", a_out, core_ba);
        check("R6 b_pin_out untouched by update", b_out, core_ab);
        op = 3'd1;
        cycle();
        check("R6 preload on A pins", a_out, vin[W-1:0]);
        check("R6 preload on B pins", b_out, vin[CW-1:W]);

        // R2: codes 5..7 act as non-driving
        for (int c = 5; c < 8; c++) begin
            op = 3'(c);
            cycle();
            check("R2 high code passes core to A", a_out, core_ba);
            check("R2 high code test_mode", tmode, 1'b0);
        end

        // R3/R4: capture several patterns and read back the chain order
        for (int p = 0; p < 6; p++) begin
            op = (p % 2 == 0) ? 3'd0 : 3'd1;
            case (p)
                0: begin a_in = '1; b_in = '0; end
                1: begin a_in = '0; b_in = '1; end
                2: begin a_in = W'(18'h2AAAA); b_in = W'(18'h15555); end
                3: begin a_in = W'(1); b_in = W'(18'h20000); end
                default: begin a_in = W'($urandom); b_in = W'($urandom); end
            endcase
            pulse_capture();
            shift_chain('0, got);
            check("R3 R4 captured chain order", got, {b_in, a_in});
        end

        // R10: capture wins over shift in the same edge
        a_in = W'(18'h0F0F0);
        b_in = W'(18'h3C3C3);
        st_capture = 1'b1;
        st_shift = 1'b1;
        tdi = 1'b1;
        cycle();
        st_capture = 1'b0;
        st_shift = 1'b0;
        tdi = 1'b0;
        shift_chain('0, got);
        check("R10 capture beats shift", got, {b_in, a_in});

        // R5: driven pins change only at update
        op = 3'd1;
        vin = {W'(18'h12345), W'(18'h2ABCD)};
        shift_chain('0, got);
        pulse_update();
        ca = a_out;
        shift_chain(vin, got);
        check("R5 A pins hold during shift", a_out, '0);
        pulse_update();
        check("R5 A pins after update", a_out, vin[W-1:0]);
        check("R5 B pins after update", b_out, vin[CW-1:W]);
        shift_chain('1, got);
        check("R5 B pins hold after later shift", b_out, vin[CW-1:W]);
        check("R4 shifted vector read back", got, vin);

        // R10: idle has no chain effect in codes without signature
        vin = {W'($urandom), W'($urandom)};
        shift_chain(vin, got);
        for (int c = 0; c < 8; c++) begin
            if (c == 2 || c == 4) continue;
            op = 3'(c);
            st_idle = 1'b1;
            cycle();
        end
        st_idle = 1'b0;
        op = 3'd2;
        repeat (3) cycle();
        shift_chain('0, got);
        check("R10 chain held", got, vin);

        // R7: signature compression on both sides
        op = 3'd2;
        ma = '0;
        mb = '0;
        for (int k = 0; k < 30; k++) begin
            a_in = (k == 0) ? '1 : W'($urandom);
            b_in = (k == 1) ? '0 : W'($urandom);
            st_idle = 1'b1;
            cycle();
            ma = lstep(ma, a_in);
            mb = lstep(mb, b_in);
        end
        st_idle = 1'b0;
        shift_chain('0, got);
        check("R7 signature both sides", got, {mb, ma});

        // R8: pattern generation from an all-zero start
        op = 3'd1;
        shift_chain('0, got);
        pulse_update();
        op = 3'd3;
        ma = '0;
        for (int k = 0; k < 40; k++) begin
            st_idle = 1'b1;
            cycle();
            ma = (ma == '0) ? W'(1) : lstep(ma, '0);
            check("R8 pattern on A pins", a_out, ma);
            check("R8 pattern on B pins", b_out, ma);
        end
        st_idle = 1'b0;

        // R9: counter wrap with signature running alongside
        op = 3'd1;
        ca = '1;
        cb = W'((1 << W) - 3);
        shift_chain({cb, ca}, got);
        pulse_update();
        op = 3'd4;
        ma = ca;
        mb = cb;
        for (int k = 0; k < 6; k++) begin
            a_in = W'($urandom);
            b_in = W'($urandom);
            st_idle = 1'b1;
            cycle();
            ca = ca + W'(1);
            cb = cb + W'(1);
            ma = lstep(ma, a_in);
            mb = lstep(mb, b_in);
            check("R9 count on A pins", a_out, ca);
            check("R9 count on B pins", b_out, cb);
        end
        st_idle = 1'b0;
        check("R9 A wrapped past all ones", a_out, W'(6 - 1));
        shift_chain('0, got);
        check("R7 signature in count mode", got, {mb, ma});

        // R1: reset again clears both register kinds
        op = 3'd1;
        shift_chain({W'(18'h3FFFF), W'(18'h3FFFF)}, got);
        pulse_update();
        rst = 1'b1;
        cycle();
        rst = 1'b0;
        cycle();
        check("R1 A pins cleared", a_out, '0);
        check("R1 B pins cleared", b_out, '0);
        shift_chain('0, got);
        check("R1 chain cleared", got, '0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule